// File: doc/BRIEF.md
# Aliased General Register Stack

A 128-word, 36-bit register file that doubles as the bottom of the data address space. Words are reached in one of two ways. A designator names a register class (index, accumulator or special) plus a 4-bit register number, and is translated to a physical word. A raw 7-bit storage address names the physical word directly. There are two combinational read ports and one write port that commits on the rising clock edge. Each port can also reach the word that follows the addressed one, which gives double-word access.

An `exec_mode` input chooses between the user and executive copies of the three register sets when a designator is translated. Raw storage addresses ignore the mode. The upper four index registers and the lower four accumulators are the same physical words. Because of this overlap, four words beyond the last named accumulator can only be reached through a raw address or as the second half of a double-word access.

Top module: `regstk_top`

## Requirements
- R1: After reset every one of the 128 words reads as zero.
- R2: Port kind code 0 is a raw storage address. The 7-bit select then addresses physical word `sel` directly, for any value of `exec_mode`.
- R3: Kind code 1 is an index register. In user mode, index register n (1..15) is physical word n.
- R4: Index registers 12..15 and accumulators 0..3 of the same mode are the same words. A write through one name is visible through the other.
- R5: Kind code 2 is an accumulator. In user mode, accumulator n (0..15) is physical word 12+n. Words 28..31 are reachable only by raw address or as the second word after accumulator 15.
- R6: Each read port also returns the word at physical address+1 (modulo 128). With `wr_pair` set, a write also stores `wr_word_nx` at physical address+1. A double-word on accumulator 15 therefore reaches word 28.
- R7: Kind code 3 is a special register. In user mode, special register n (1..15) is physical word 64+n.
- R8: With `exec_mode` high, designators translate to the executive copies: index n is word 80+n, accumulator n is word 92+n, special n is word 112+n.
- R9: Index number 0 and special number 0 read as zero on both words of a port. A write to either changes no word.
- R10: A read of a word that is written in the same cycle returns the old value. The new value is visible from the cycle after the clock edge.
- R11: The two read ports operate independently and at the same time, each with its own kind, select and outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears all words |
| exec_mode | input | 1 | 1 selects executive register copies for designators |
| ra_kind | input | 2 | Read port A kind: 0 raw, 1 index, 2 accumulator, 3 special |
| ra_sel | input | 7 | Read port A raw address, or register number in bits 3:0 |
| ra_word | output | 36 | Read port A addressed word |
| ra_word_nx | output | 36 | Read port A following word |
| rb_kind | input | 2 | Read port B kind |
| rb_sel | input | 7 | Read port B select |
| rb_word | output | 36 | Read port B addressed word |
| rb_word_nx | output | 36 | Read port B following word |
| wr_en | input | 1 | Write request |
| wr_pair | input | 1 | Also write the following word |
| wr_kind | input | 2 | Write port kind |
| wr_sel | input | 7 | Write port select |
| wr_word | input | 36 | Data for the addressed word |
| wr_word_nx | input | 36 | Data for the following word |

## Verification
The bench writes a distinct value through every designator in both modes. After each write it reads the expected physical word back by raw address, so a wrong base offset or a missed mode switch shows up as data in the wrong place. It writes index registers 12..15 and reads the matching accumulators to catch a design that keeps the overlapping names in separate words. It also runs a double-word write on accumulator 15 and another on raw address 127, which exposes wrong carry and wrap handling of the second word. Writes to index and special register 0 are followed by a scan of the whole array to prove nothing moved. A read of the word being written in the same cycle is compared against the old value, which catches a design that forwards write data.

// File: rtl/regstk_pkg.sv
package regstk_pkg;

  typedef enum logic [1:0] {
    KIND_RAW = 2'd0,
    KIND_IDX = 2'd1,
    KIND_ACC = 2'd2,
    KIND_SPC = 2'd3
  } reg_kind_e;

  localparam int unsigned STK_AW    = 7;
  localparam int unsigned STK_DEPTH = 1 << STK_AW;
  localparam int unsigned NUM_W     = 4;

  // physical bases of each set; index/accumulator overlap is 12 words apart
  localparam int unsigned OVL_OFS    = 12;
  localparam int unsigned USR_X_BASE = 0;
  localparam int unsigned USR_A_BASE = USR_X_BASE + OVL_OFS;
  localparam int unsigned USR_R_BASE = 64;
  localparam int unsigned EXE_X_BASE = 80;
  localparam int unsigned EXE_A_BASE = EXE_X_BASE + OVL_OFS;
  localparam int unsigned EXE_R_BASE = 112;

  typedef struct packed {
    logic              nul;
    logic [STK_AW-1:0] phys;
  } xlat_t;

  function automatic xlat_t map_designator(input logic [1:0] kind,
                                           input logic [STK_AW-1:0] sel,
                                           input logic exe);
    xlat_t r;
    logic [NUM_W-1:0] n;
    int unsigned base;
    n     = sel[NUM_W-1:0];
    r.nul = 1'b0;
    base  = 0;
    case (reg_kind_e'(kind))
      KIND_IDX: begin base = exe ? EXE_X_BASE : USR_X_BASE; r.nul = (n == '0); end
      KIND_ACC: base = exe ? EXE_A_BASE : USR_A_BASE;
      KIND_SPC: begin base = exe ? EXE_R_BASE : USR_R_BASE; r.nul = (n == '0); end
      default:  base = 0;
    endcase
    if (reg_kind_e'(kind) == KIND_RAW) r.phys = sel;
    else r.phys = STK_AW'(base + int'(n));
    return r;
  endfunction

endpackage

// File: rtl/regstk_xlate.sv
module regstk_xlate
  import regstk_pkg::*;
(
  input  logic [1:0]        kind,
  input  logic [STK_AW-1:0] sel,
  input  logic              exe,
  output logic [STK_AW-1:0] phys,
  output logic [STK_AW-1:0] phys_nx,
  output logic              nul
);
  xlat_t x;
  always_comb x = map_designator(kind, sel, exe);
  assign phys    = x.phys;
  assign phys_nx = x.phys + STK_AW'(1);
  assign nul     = x.nul;
endmodule

// File: rtl/regstk_bank.sv
module regstk_bank #(
  parameter int unsigned WORD_W = 36,
  parameter int unsigned AW     = 7,
  parameter int unsigned NRD    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we0,
  input  logic [AW-1:0]     wa0,
  input  logic [WORD_W-1:0] wd0,
  input  logic              we1,
  input  logic [AW-1:0]     wa1,
  input  logic [WORD_W-1:0] wd1,
  input  logic [AW-1:0]     ra [NRD],
  output logic [WORD_W-1:0] rq [NRD]
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else begin
      if (we0) mem[wa0] <= wd0;
      if (we1) mem[wa1] <= wd1;
    end
  end

  for (genvar g = 0; g < int'(NRD); g++) begin : g_rd
    assign rq[g] = mem[ra[g]];
  end
endmodule

// File: rtl/regstk_top.sv
module regstk_top
  import regstk_pkg::*;
#(
  parameter int unsigned WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_mode,
  input  logic [1:0]        ra_kind,
  input  logic [6:0]        ra_sel,
  output logic [WORD_W-1:0] ra_word,
  output logic [WORD_W-1:0] ra_word_nx,
  input  logic [1:0]        rb_kind,
  input  logic [6:0]        rb_sel,
  output logic [WORD_W-1:0] rb_word,
  output logic [WORD_W-1:0] rb_word_nx,
  input  logic              wr_en,
  input  logic              wr_pair,
  input  logic [1:0]        wr_kind,
  input  logic [6:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [WORD_W-1:0] wr_word_nx
);
  localparam int unsigned NPORT = 2;
  localparam int unsigned NRD   = 2 * NPORT;

  logic [1:0]        p_kind [NPORT];
  logic [STK_AW-1:0] p_sel  [NPORT];
  logic [STK_AW-1:0] p_phys [NPORT];
  logic [STK_AW-1:0] p_nx   [NPORT];
  logic              p_nul  [NPORT];
  logic [STK_AW-1:0] bank_ra [NRD];
  logic [WORD_W-1:0] bank_rq [NRD];
  logic [WORD_W-1:0] p_q    [NPORT];
  logic [WORD_W-1:0] p_q_nx [NPORT];

  // named internal events, used by the checker
  logic [STK_AW-1:0] ra_phys, rb_phys, wr_phys, wr_phys_nx;
  logic              ra_null, rb_null, wr_null, wr_fire, wr_fire_nx;

  assign p_kind[0] = ra_kind;
  assign p_kind[1] = rb_kind;
  assign p_sel[0]  = ra_sel;
  assign p_sel[1]  = rb_sel;

  for (genvar g = 0; g < int'(NPORT); g++) begin : g_port
    regstk_xlate u_xl (
      .kind    (p_kind[g]),
      .sel     (p_sel[g]),
      .exe     (exec_mode),
      .phys    (p_phys[g]),
      .phys_nx (p_nx[g]),
      .nul     (p_nul[g])
    );
    assign bank_ra[2*g]   = p_phys[g];
    assign bank_ra[2*g+1] = p_nx[g];
    assign p_q[g]    = p_nul[g] ? '0 : bank_rq[2*g];
    assign p_q_nx[g] = p_nul[g] ? '0 : bank_rq[2*g+1];
  end

  regstk_xlate u_wxl (
    .kind    (wr_kind),
    .sel     (wr_sel),
    .exe     (exec_mode),
    .phys    (wr_phys),
    .phys_nx (wr_phys_nx),
    .nul     (wr_null)
  );

  assign wr_fire    = wr_en & ~wr_null;
  assign wr_fire_nx = wr_fire & wr_pair;

  regstk_bank #(.WORD_W(WORD_W), .AW(STK_AW), .NRD(NRD)) u_bank (
    .clk (clk),
    .rst_n (rst_n),
    .we0 (wr_fire),
    .wa0 (wr_phys),
    .wd0 (wr_word),
    .we1 (wr_fire_nx),
    .wa1 (wr_phys_nx),
    .wd1 (wr_word_nx),
    .ra  (bank_ra),
    .rq  (bank_rq)
  );

  assign ra_phys    = p_phys[0];
  assign rb_phys    = p_phys[1];
  assign ra_null    = p_nul[0];
  assign rb_null    = p_nul[1];
  assign ra_word    = p_q[0];
  assign ra_word_nx = p_q_nx[0];
  assign rb_word    = p_q[1];
  assign rb_word_nx = p_q_nx[1];
endmodule

// File: rtl/regstk_chk.sv
module regstk_chk #(
  parameter int unsigned WORD_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exec_mode,
  input logic [1:0]        ra_kind,
  input logic [6:0]        ra_sel,
  input logic [WORD_W-1:0] ra_word,
  input logic [WORD_W-1:0] ra_word_nx,
  input logic [1:0]        rb_kind,
  input logic [6:0]        rb_sel,
  input logic [WORD_W-1:0] rb_word,
  input logic              wr_en,
  input logic              wr_pair,
  input logic [WORD_W-1:0] wr_word,
  input logic [6:0]        ra_phys,
  input logic              ra_null,
  input logic [6:0]        wr_phys,
  input logic              wr_fire
);
  // R2
  raw_mode_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_kind == 2'd0 && $stable(ra_kind) && $stable(ra_sel) && !$past(wr_en))
      |-> $stable(ra_word));

  // R4
  overlap_same_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_kind == 2'd1 && ra_sel[3:0] >= 4'd12 && rb_kind == 2'd2 &&
     rb_sel[3:0] == ra_sel[3:0] - 4'd12) |-> (ra_word == rb_word));

  // R6
  pair_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_kind == 2'd2 && rb_kind == 2'd2 && ra_sel[3:0] != 4'd15 &&
     rb_sel[3:0] == ra_sel[3:0] + 4'd1) |-> (ra_word_nx == rb_word));

  // R9
  null_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ra_kind == 2'd1 || ra_kind == 2'd3) && ra_sel[3:0] == 4'd0)
      |-> (ra_word == '0 && ra_word_nx == '0));

  // R10
  write_then_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !wr_pair && !ra_null && ra_phys == wr_phys)
      |=> ($stable(ra_phys) && !ra_null) |-> (ra_word == $past(wr_word)));

  // R8
  exec_moves_designator_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_kind != 2'd0 && $stable(ra_kind) && $stable(ra_sel) && exec_mode != $past(exec_mode))
      |-> !$stable(ra_phys));
endmodule

bind regstk_top regstk_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .exec_mode  (exec_mode),
  .ra_kind    (ra_kind),
  .ra_sel     (ra_sel),
  .ra_word    (ra_word),
  .ra_word_nx (ra_word_nx),
  .rb_kind    (rb_kind),
  .rb_sel     (rb_sel),
  .rb_word    (rb_word),
  .wr_en      (wr_en),
  .wr_pair    (wr_pair),
  .wr_word    (wr_word),
  .ra_phys    (ra_phys),
  .ra_null    (ra_null),
  .wr_phys    (wr_phys),
  .wr_fire    (wr_fire)
);

// File: tb/tb_regstk_top.sv
module tb_regstk_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exec_mode = 1'b0;
  logic [1:0] ra_kind = '0, rb_kind = '0, wr_kind = '0;
  logic [6:0] ra_sel = '0, rb_sel = '0, wr_sel = '0;
  logic [35:0] ra_word, ra_word_nx, rb_word, rb_word_nx;
  logic wr_en = 1'b0, wr_pair = 1'b0;
  logic [35:0] wr_word = '0, wr_word_nx = '0;

  int checks = 0;
  int errors = 0;
  logic [35:0] mdl [128];

  always #5 clk = ~clk;

  regstk_top dut (
    .clk(clk), .rst_n(rst_n), .exec_mode(exec_mode),
    .ra_kind(ra_kind), .ra_sel(ra_sel), .ra_word(ra_word), .ra_word_nx(ra_word_nx),
    .rb_kind(rb_kind), .rb_sel(rb_sel), .rb_word(rb_word), .rb_word_nx(rb_word_nx),
    .wr_en(wr_en), .wr_pair(wr_pair), .wr_kind(wr_kind), .wr_sel(wr_sel),
    .wr_word(wr_word), .wr_word_nx(wr_word_nx)
  );

  // physical word of a designator, -1 for the null registers
  function automatic int bmap(int kind, int n, int mode);
    case (kind)
      1: return (n == 0) ? -1 : n + 80 * mode;
      2: return 12 + n + 80 * mode;
      3: return (n == 0) ? -1 : 64 + 48 * mode + n;
      default: return n % 128;
    endcase
  endfunction

  function automatic logic [35:0] pat(int mode, int kind, int n);
    return 36'h9_0000_0000 | 36'(mode * 4096 + kind * 256 + n * 2 + 1);
  endfunction

  task automatic chk(string tag, logic [35:0] got, logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(int kind, int sel, int mode, bit pair, logic [35:0] d0, logic [35:0] d1);
    int a;
    @(negedge clk);
    exec_mode = mode[0]; wr_kind = kind[1:0]; wr_sel = sel[6:0];
    wr_pair = pair; wr_word = d0; wr_word_nx = d1; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_pair = 1'b0;
    a = bmap(kind, sel, mode);
    if (a >= 0) begin
      mdl[a] = d0;
      if (pair) mdl[(a + 1) % 128] = d1;
    end
  endtask

  task automatic rd(int ka, int sa, int kb, int sb, int mode);
    @(negedge clk);
    exec_mode = mode[0];
    ra_kind = ka[1:0]; ra_sel = sa[6:0]; rb_kind = kb[1:0]; rb_sel = sb[6:0];
    #2;
  endtask

  task automatic scan(string tag, int mode);
    for (int i = 0; i < 128; i++) begin
      rd(0, i, 0, 127 - i, mode);
      chk(tag, ra_word, mdl[i]);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    scan("R1 reset", 0);

    // designator writes in both modes, checked by raw address
    for (int m = 0; m < 2; m++)
      for (int k = 1; k < 4; k++)
        for (int n = 0; n < 16; n++) begin
          int a;
          string tg;
          wr(k, n, m, 1'b0, pat(m, k, n), '0);
          a = bmap(k, n, m);
          tg = (m == 1) ? "R8 exec map" : (k == 1) ? "R3 index map" :
               (k == 2) ? "R5 acc map" : "R7 special map";
          if (a >= 0) begin
            rd(0, a, 0, 0, 1 - m);
            chk(tg, ra_word, pat(m, k, n));
          end
        end

    // R9 null writes moved nothing; R2 raw access ignores mode
    scan("R9 null write", 0);
    scan("R2 raw exec", 1);

    // designator reads, both words, both ports
    for (int m = 0; m < 2; m++)
      for (int k = 1; k < 4; k++)
        for (int n = 0; n < 16; n++) begin
          int a;
          a = bmap(k, n, m);
          rd(k, n, k, n, m);
          chk((a < 0) ? "R9 null read" : "R8 designator read", ra_word, (a < 0) ? '0 : mdl[a]);
          chk((a < 0) ? "R9 null read nx" : "R6 next word", ra_word_nx,
              (a < 0) ? '0 : mdl[(a + 1) % 128]);
          chk("R11 port b", rb_word, (a < 0) ? '0 : mdl[a]);
        end

    // R4 overlap through both names
    for (int m = 0; m < 2; m++)
      for (int n = 12; n < 16; n++) begin
        wr(1, n, m, 1'b0, 36'hA_5000_0000 | 36'(n * 7 + m), '0);
        rd(2, n - 12, 1, n, m);
        chk("R4 index->acc", ra_word, 36'hA_5000_0000 | 36'(n * 7 + m));
        wr(2, n - 12, m, 1'b0, 36'h3_C000_0000 | 36'(n * 5 + m), '0);
        rd(1, n, 2, n - 12, m);
        chk("R4 acc->index", ra_word, 36'h3_C000_0000 | 36'(n * 5 + m));
      end

    // R5/R6 double word on accumulator 15 reaches word 28
    wr(2, 15, 0, 1'b1, 36'h1_1111_1111, 36'h2_2222_2222);
    rd(0, 27, 0, 28, 1);
    chk("R6 pair lo", ra_word, 36'h1_1111_1111);
    chk("R6 pair hi", rb_word, 36'h2_2222_2222);
    wr(0, 29, 0, 1'b0, 36'h7_7777_0029, '0);
    rd(0, 29, 2, 15, 0);
    chk("R5 extra by raw", ra_word, 36'h7_7777_0029);
    chk("R5 acc15 nx", rb_word_nx, 36'h2_2222_2222);

    // R6 raw pair at 127 wraps to word 0
    wr(0, 127, 1, 1'b1, 36'hE_0000_0127, 36'hE_0000_0000);
    rd(0, 127, 0, 0, 0);
    chk("R6 wrap lo", ra_word, 36'hE_0000_0127);
    chk("R6 wrap hi", rb_word, 36'hE_0000_0000);
    chk("R6 wrap nx", ra_word_nx, 36'hE_0000_0000);

    // R10 read during write returns old value
    @(negedge clk);
    ra_kind = 2'd0; ra_sel = 7'd40;
    wr_kind = 2'd0; wr_sel = 7'd40; wr_word = 36'hF_0F0F_0F0F; wr_pair = 1'b0; wr_en = 1'b1;
    #2;
    chk("R10 old value", ra_word, mdl[40]);
    @(negedge clk);
    wr_en = 1'b0;
    mdl[40] = 36'hF_0F0F_0F0F;
    #2;
    chk("R10 new value", ra_word, 36'hF_0F0F_0F0F);

    // R11 independent simultaneous ports
    for (int i = 0; i < 128; i += 9) begin
      rd(0, i, 0, 127 - i, i % 2);
      chk("R11 port a", ra_word, mdl[i]);
      chk("R11 port b", rb_word, mdl[127 - i]);
    end

    scan("R9 final", 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule